// File: doc/BRIEF.md
# Vector-Chained Descriptor DMA Engine

This block moves data from memory to memory whenever a qualified interrupt request arrives. It does not hold any transfer state in registers between requests. Each request names a source index. The engine reads that source's 32-bit entry in a vector table kept in RAM, and the low half of the entry is the address of a 12-byte descriptor. The engine fetches the descriptor, performs one unit transfer (or a whole burst), and then stores the updated counter and addresses back into the same descriptor. The next request for that source therefore resumes where the previous one stopped.

When a descriptor's counter runs out and its chain bit is set, the engine overwrites the requesting source's vector entry with the descriptor's 32-bit chain address. The following request from that source then runs from a new descriptor. The only connection to the rest of the system is one 16-bit memory master port with a ready handshake. Requests below the accepted priority level are not served.

Top module: `vdma_chain_engine`

## Requirements
- R1: A served request first reads the 16-bit word at `vec_base + 4*req_src`, and uses it as the descriptor base. The descriptor words sit at base+0 (mode), +2 (count), +4 (source), +6 (destination), +8 (chain low) and +10 (chain high).
- R2: Mode bits that have an effect: bit0 selects a 16-bit unit (0 gives 8-bit); bit1 selects a memory source (0 gives immediate); bit2 makes the source advance; bit3 makes the destination advance; bit5 selects burst; bit7 enables chaining. All other mode bits have no effect.
- R3: Without burst, a request performs exactly one unit transfer and decrements the count by one. It then writes the count, source and destination back to base+2, base+4 and base+6, in that order.
- R4: An advancing address moves by 1 after an 8-bit unit and by 2 after a 16-bit unit. A fixed address does not change.
- R5: An 8-bit write goes to the even-aligned word address, with `mem_be` 01 for an even byte and 10 for an odd byte, and the byte is repeated in both halves of `mem_wdata`. An 8-bit read takes the byte lane picked by the address LSB. 16-bit accesses use `mem_be` 11.
- R6: With an immediate source, the source field is the data written (its low byte for 8-bit units), and no source read is made.
- R7: With burst, one request repeats unit transfers until the count reaches 0, followed by a single write-back.
- R8: When the count reaches 0 with chaining on, chain low is written to the vector entry and chain high to entry+2, after the write-back. `done` then pulses.
- R9: When the count reaches 0 with chaining off, the vector entry is not written, and `done` is high for exactly one cycle.
- R10: A descriptor whose count is already 0 causes no write and no `done`.
- R11: Only requests with `req_lvl` equal to 7 are served. All others are ignored.
- R12: An accepted request that arrives while busy is held in a single pending slot. It is served after the current operation ends, in arrival order.
- R13: A memory access keeps its request, address, write enable and data stable until `mem_ready`. `busy` is high exactly while an operation is in progress, and there are no accesses while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_src | input | SRC_W | Requesting source index |
| req_lvl | input | LVL_W | Priority level of the request |
| vec_base | input | 16 | Byte address of the vector table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Even-aligned byte address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte enables for writes |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes on this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when a descriptor is exhausted |

## Verification
The properties assume the following about the block's inputs:
- The memory raises `mem_ready` only while `mem_req` is high.
- Read data is valid in the same cycle as `mem_ready`.
- Descriptors and vector entries are even-aligned.
- 16-bit units use even addresses.

The stimulus keeps within these assumptions:
- A responder that inserts zero to two wait cycles per access.
- Descriptors placed at even addresses.
- At most one request issued while the engine is already busy, so the pending slot never overflows.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int WORD_W    = 16;
  localparam int IDX_W     = 3;
  localparam int DESC_LAST = 5;  // six descriptor words
  localparam int WB_LAST   = 2;  // three write-back words
  localparam int VEC_LAST  = 1;  // two vector halves

  localparam int MB_UNIT16 = 0;
  localparam int MB_MEMSRC = 1;
  localparam int MB_SFWD   = 2;
  localparam int MB_DFWD   = 3;
  localparam int MB_BURST  = 5;
  localparam int MB_CHAIN  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_DESC, ST_SRC, ST_DST, ST_WB, ST_CHN
  } vdma_state_e;

  typedef struct packed {
    logic unit16;
    logic memsrc;
    logic sfwd;
    logic dfwd;
    logic burst;
    logic chain;
  } vdma_ctl_t;
endpackage

// File: rtl/vdma_req_slot.sv
module vdma_req_slot #(
  parameter int SRC_W      = 5,
  parameter int LVL_W      = 3,
  parameter int ACCEPT_LVL = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [SRC_W-1:0] req_src,
  input  logic             take,
  output logic             pend_v,
  output logic [SRC_W-1:0] pend_src
);
  localparam logic [LVL_W-1:0] LVL_OK = LVL_W'(ACCEPT_LVL);

  logic             accept;
  logic             v_n;
  logic [SRC_W-1:0] src_n;

  always_comb begin
    accept = req_valid && (req_lvl == LVL_OK) && (!pend_v || take);
    v_n    = pend_v;
    src_n  = pend_src;
    if (accept) begin
      v_n   = 1'b1;
      src_n = req_src;
    end else if (take) begin
      v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_src <= '0;
    end else begin
      pend_v <= v_n;
      if (accept) pend_src <= src_n;
    end
  end
endmodule

// File: rtl/vdma_step.sv
module vdma_step
  import vdma_pkg::*;
(
  input  logic              unit16,
  input  logic              sfwd,
  input  logic              dfwd,
  input  logic [WORD_W-1:0] cnt,
  input  logic [WORD_W-1:0] sadr,
  input  logic [WORD_W-1:0] dadr,
  output logic [WORD_W-1:0] cnt_nx,
  output logic [WORD_W-1:0] sadr_nx,
  output logic [WORD_W-1:0] dadr_nx,
  output logic              last
);
  logic [WORD_W-1:0] inc;

  always_comb begin
    inc     = unit16 ? WORD_W'(2) : WORD_W'(1);
    cnt_nx  = cnt - WORD_W'(1);
    sadr_nx = sfwd ? sadr + inc : sadr;
    dadr_nx = dfwd ? dadr + inc : dadr;
    last    = (cnt_nx == '0);
  end
endmodule

// File: rtl/vdma_lane.sv
module vdma_lane
  import vdma_pkg::*;
(
  input  logic              unit16,
  input  logic              rd_lsb,
  input  logic              wr_lsb,
  input  logic [WORD_W-1:0] rdata,
  input  logic [WORD_W-1:0] wsrc,
  output logic [WORD_W-1:0] rd_val,
  output logic [WORD_W-1:0] wr_word,
  output logic [1:0]        wr_be
);
  localparam int HB = WORD_W / 2;

  always_comb begin
    if (unit16) begin
      rd_val  = rdata;
      wr_word = wsrc;
      wr_be   = 2'b11;
    end else begin
      rd_val  = {{HB{1'b0}}, (rd_lsb ? rdata[WORD_W-1:HB] : rdata[HB-1:0])};
      wr_word = {wsrc[HB-1:0], wsrc[HB-1:0]};
      wr_be   = wr_lsb ? 2'b10 : 2'b01;
    end
  end
endmodule

// File: rtl/vdma_chain_engine.sv
module vdma_chain_engine
  import vdma_pkg::*;
#(
  parameter int SRC_W      = 5,
  parameter int LVL_W      = 3,
  parameter int ACCEPT_LVL = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [WORD_W-1:0] vec_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [1:0]        mem_be,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done
);
  vdma_state_e       st_q, st_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [WORD_W-1:0] vec_q, vec_n, base_q, base_n;
  logic [WORD_W-1:0] cnt_q, cnt_n, sadr_q, sadr_n, dadr_q, dadr_n;
  logic [WORD_W-1:0] cad0_q, cad0_n, cad1_q, cad1_n, xdat_q, xdat_n;
  vdma_ctl_t         ctl_q, ctl_n;
  logic              done_q, done_n;

  logic              take, pend_v, ack, last;
  logic [SRC_W-1:0]  pend_src;
  logic [WORD_W-1:0] cnt_st, sadr_st, dadr_st;
  logic [WORD_W-1:0] rd_val, wr_word, wsrc;
  logic [1:0]        wr_be;

  vdma_req_slot #(.SRC_W(SRC_W), .LVL_W(LVL_W), .ACCEPT_LVL(ACCEPT_LVL)) u_slot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lvl(req_lvl),
    .req_src(req_src), .take(take), .pend_v(pend_v), .pend_src(pend_src)
  );

  vdma_step u_step (
    .unit16(ctl_q.unit16), .sfwd(ctl_q.sfwd), .dfwd(ctl_q.dfwd),
    .cnt(cnt_q), .sadr(sadr_q), .dadr(dadr_q),
    .cnt_nx(cnt_st), .sadr_nx(sadr_st), .dadr_nx(dadr_st), .last(last)
  );

  assign wsrc = ctl_q.memsrc ? xdat_q : sadr_q;

  vdma_lane u_lane (
    .unit16(ctl_q.unit16), .rd_lsb(sadr_q[0]), .wr_lsb(dadr_q[0]),
    .rdata(mem_rdata), .wsrc(wsrc),
    .rd_val(rd_val), .wr_word(wr_word), .wr_be(wr_be)
  );

  assign ack  = mem_req && mem_ready;
  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  // memory port drive
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = 2'b11;
    case (st_q)
      ST_VEC: begin
        mem_req  = 1'b1;
        mem_addr = vec_q;
      end
      ST_DESC: begin
        mem_req  = 1'b1;
        mem_addr = base_q + WORD_W'({idx_q, 1'b0});
      end
      ST_SRC: begin
        mem_req  = 1'b1;
        mem_addr = {sadr_q[WORD_W-1:1], 1'b0};
      end
      ST_DST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {dadr_q[WORD_W-1:1], 1'b0};
        mem_wdata = wr_word;
        mem_be    = wr_be;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + WORD_W'(2) + WORD_W'({idx_q, 1'b0});
        mem_wdata = (idx_q == 3'd0) ? cnt_q : (idx_q == 3'd1) ? sadr_q : dadr_q;
      end
      ST_CHN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = vec_q + WORD_W'({idx_q, 1'b0});
        mem_wdata = (idx_q == 3'd0) ? cad0_q : cad1_q;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_n   = st_q;   idx_n  = idx_q;  vec_n  = vec_q;  base_n = base_q;
    cnt_n  = cnt_q;  sadr_n = sadr_q; dadr_n = dadr_q;
    cad0_n = cad0_q; cad1_n = cad1_q; xdat_n = xdat_q; ctl_n  = ctl_q;
    done_n = 1'b0;
    take   = 1'b0;
    case (st_q)
      ST_IDLE: if (pend_v) begin
        take  = 1'b1;
        vec_n = vec_base + (WORD_W'(pend_src) << 2);
        st_n  = ST_VEC;
      end
      ST_VEC: if (ack) begin
        base_n = mem_rdata;
        idx_n  = '0;
        st_n   = ST_DESC;
      end
      ST_DESC: if (ack) begin
        case (idx_q)
          3'd0: ctl_n = '{unit16: mem_rdata[MB_UNIT16], memsrc: mem_rdata[MB_MEMSRC],
                          sfwd: mem_rdata[MB_SFWD], dfwd: mem_rdata[MB_DFWD],
                          burst: mem_rdata[MB_BURST], chain: mem_rdata[MB_CHAIN]};
          3'd1: cnt_n  = mem_rdata;
          3'd2: sadr_n = mem_rdata;
          3'd3: dadr_n = mem_rdata;
          3'd4: cad0_n = mem_rdata;
          default: cad1_n = mem_rdata;
        endcase
        if (idx_q == IDX_W'(DESC_LAST)) begin
          if (cnt_q == '0)        st_n = ST_IDLE;
          else if (ctl_q.memsrc)  st_n = ST_SRC;
          else                    st_n = ST_DST;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_SRC: if (ack) begin
        xdat_n = rd_val;
        st_n   = ST_DST;
      end
      ST_DST: if (ack) begin
        cnt_n  = cnt_st;
        sadr_n = sadr_st;
        dadr_n = dadr_st;
        idx_n  = '0;
        if (ctl_q.burst && !last) st_n = ctl_q.memsrc ? ST_SRC : ST_DST;
        else                      st_n = ST_WB;
      end
      ST_WB: if (ack) begin
        if (idx_q == IDX_W'(WB_LAST)) begin
          idx_n = '0;
          if (cnt_q != '0) begin
            st_n = ST_IDLE;
          end else if (ctl_q.chain) begin
            st_n = ST_CHN;
          end else begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_CHN: if (ack) begin
        if (idx_q == IDX_W'(VEC_LAST)) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE; idx_q  <= '0; vec_q  <= '0; base_q <= '0;
      cnt_q  <= '0;      sadr_q <= '0; dadr_q <= '0;
      cad0_q <= '0;      cad1_q <= '0; xdat_q <= '0;
      ctl_q  <= '0;      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      done_q <= done_n;
      if (take) vec_q <= vec_n;
      if (ack) begin
        base_q <= base_n; cnt_q  <= cnt_n;  sadr_q <= sadr_n; dadr_q <= dadr_n;
        cad0_q <= cad0_n; cad1_q <= cad1_n; xdat_q <= xdat_n; ctl_q  <= ctl_n;
      end
    end
  end
endmodule

// File: rtl/vdma_chain_checker.sv
module vdma_chain_checker #(
  parameter int LVL_W      = 3,
  parameter int ACCEPT_LVL = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LVL_W-1:0] req_lvl,
  input logic             busy,
  input logic             done,
  input logic             pend_v,
  input logic             mem_req,
  input logic             mem_ready,
  input logic             mem_we,
  input logic [15:0]      mem_addr,
  input logic [15:0]      mem_wdata,
  input logic [1:0]       mem_be
);
  localparam logic [LVL_W-1:0] LVL_OK = LVL_W'(ACCEPT_LVL);

  p_hold_access_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_lane_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 2'b00));

  p_level_filter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pend_v && !(req_valid && req_lvl == LVL_OK)) |=> !busy);
endmodule

bind vdma_chain_engine vdma_chain_checker #(.LVL_W(LVL_W), .ACCEPT_LVL(ACCEPT_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lvl(req_lvl),
  .busy(busy), .done(done), .pend_v(pend_v), .mem_req(mem_req),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_be(mem_be)
);

// File: tb/test_vdma_chain_engine.sv
module test_vdma_chain_engine;
  localparam logic [15:0] VBASE = 16'h0040;

  logic        clk, rst_n;
  logic        req_valid;
  logic [4:0]  req_src;
  logic [2:0]  req_lvl;
  logic [15:0] vec_base;
  logic        mem_req, mem_we, mem_ready, busy, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;

  vdma_chain_engine i_vdma_chain_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_lvl(req_lvl), .vec_base(vec_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  mem   [0:4095];
  logic [7:0]  ref_m [0:4095];
  logic [33:0] exp_q [$];
  int checks = 0, fails = 0, exp_done = 0, got_done = 0;
  int wcnt = 0, pat = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rref16(input logic [15:0] a);
    return {ref_m[{a[11:1], 1'b1}], ref_m[{a[11:1], 1'b0}]};
  endfunction

  function automatic logic [15:0] rmem16(input logic [15:0] a);
    return {mem[{a[11:1], 1'b1}], mem[{a[11:1], 1'b0}]};
  endfunction

  task automatic poke16(input logic [15:0] a, input logic [15:0] v);
    mem[{a[11:1], 1'b0}] = v[7:0];   mem[{a[11:1], 1'b1}] = v[15:8];
    ref_m[{a[11:1], 1'b0}] = v[7:0]; ref_m[{a[11:1], 1'b1}] = v[15:8];
  endtask

  task automatic put_desc(input logic [15:0] b, input logic [15:0] md, input logic [15:0] c,
                          input logic [15:0] s, input logic [15:0] d, input logic [31:0] ch);
    poke16(b, md); poke16(b + 2, c); poke16(b + 4, s); poke16(b + 6, d);
    poke16(b + 8, ch[15:0]); poke16(b + 10, ch[31:16]);
  endtask

  // push an expected write and apply it to the reference image
  task automatic expect_wr(input logic [15:0] a, input logic [15:0] v, input logic [1:0] be);
    exp_q.push_back({a, v, be});
    if (be[0]) ref_m[{a[11:1], 1'b0}] = v[7:0];
    if (be[1]) ref_m[{a[11:1], 1'b1}] = v[15:8];
  endtask

  // reference model of one served request (R1-R10)
  task automatic model_req(input int src);
    logic [15:0] ve, base, md, cnt, s, d, c0, c1, dat, stp;
    logic [1:0]  be;
    ve   = VBASE + 16'(src * 4);
    base = rref16(ve);
    md   = rref16(base);
    cnt  = rref16(base + 2);
    s    = rref16(base + 4);
    d    = rref16(base + 6);
    c0   = rref16(base + 8);
    c1   = rref16(base + 10);
    if (cnt == 16'd0) return;           // R10
    stp = md[0] ? 16'd2 : 16'd1;        // R4
    while (1) begin
      if (md[1]) dat = md[0] ? rref16(s) : {8'h00, ref_m[s[11:0]]};
      else       dat = s;               // R6
      if (md[0]) be = 2'b11;
      else begin
        dat = {dat[7:0], dat[7:0]};     // R5
        be  = d[0] ? 2'b10 : 2'b01;
      end
      expect_wr({d[15:1], 1'b0}, dat, be);
      cnt = cnt - 1;
      if (md[2]) s = s + stp;
      if (md[3]) d = d + stp;
      if (!md[5] || cnt == 16'd0) break; // R3 / R7
    end
    expect_wr(base + 2, cnt, 2'b11);
    expect_wr(base + 4, s, 2'b11);
    expect_wr(base + 6, d, 2'b11);
    if (cnt == 16'd0) begin
      if (md[7]) begin                  // R8
        expect_wr(ve, c0, 2'b11);
        expect_wr(ve + 2, c1, 2'b11);
      end
      exp_done++;
    end
  endtask

  // driver
  task automatic fire(input int src, input logic [2:0] lvl);
    @(negedge clk);
    req_valid = 1'b1;
    req_src   = 5'(src);
    req_lvl   = lvl;
    if (lvl == 3'd7) model_req(src);    // R11: others produce nothing
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
    check(exp_q.size() == 0, req, "pending expected writes", 34'(exp_q.size()), 34'd0);
    check(got_done == exp_done, req, "done pulse count", 34'(got_done), 34'(exp_done));
  endtask

  // memory responder and monitor (all on the falling edge)
  always @(negedge clk) begin
    if (done) got_done++;
    if (mem_ready) begin
      mem_ready = 1'b0;
      pat  = (pat + 1) % 3;
      wcnt = pat;
    end else if (mem_req) begin
      if (wcnt > 0) wcnt--;
      else begin
        mem_ready = 1'b1;
        if (mem_we) begin
          if (mem_be[0]) mem[{mem_addr[11:1], 1'b0}] = mem_wdata[7:0];
          if (mem_be[1]) mem[{mem_addr[11:1], 1'b1}] = mem_wdata[15:8];
          if (exp_q.size() == 0)
            check(1'b0, "R11", "unexpected write", {mem_addr, mem_wdata, mem_be}, 34'd0);
          else begin
            logic [33:0] e;
            e = exp_q.pop_front();
            check({mem_addr, mem_wdata, mem_be} == e, "R3", "scoreboard write",
                  {mem_addr, mem_wdata, mem_be}, e);
          end
        end else begin
          mem_rdata = rmem16(mem_addr);
        end
      end
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_src = '0; req_lvl = '0;
    vec_base = VBASE; mem_ready = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'h00; ref_m[i] = 8'h00; end
    // vector entries (R1)
    poke16(16'h004C, 16'h0100); poke16(16'h004E, 16'h0000); // src 3
    poke16(16'h0054, 16'h01C0); poke16(16'h0056, 16'h0000); // src 5
    poke16(16'h0058, 16'h0220); poke16(16'h005A, 16'h0000); // src 6
    // A: 8-bit, memory, src forward, dst fixed odd, chain to B
    put_desc(16'h0100, 16'h0086, 16'd2, 16'h0600, 16'h0301, 32'h0000_0180);
    // B: 8-bit, memory, both forward, reserved bit14 set, no chain
    put_desc(16'h0180, 16'h400E, 16'd1, 16'h0611, 16'h0310, 32'h0000_0000);
    // C: 16-bit immediate, dst forward, end-interrupt bit set (no effect)
    put_desc(16'h01C0, 16'h0049, 16'd2, 16'hBEEF, 16'h0320, 32'h0000_0000);
    // D: 16-bit, memory, both forward, burst, chain to F
    put_desc(16'h0220, 16'h00AF, 16'd3, 16'h0640, 16'h0340, 32'hABCD_0260);
    // F: exhausted descriptor
    put_desc(16'h0260, 16'h0086, 16'd0, 16'h0600, 16'h0300, 32'h0000_0100);
    poke16(16'h0600, 16'h2211);
    poke16(16'h0610, 16'h5A00);
    poke16(16'h0640, 16'h1234); poke16(16'h0642, 16'h5678); poke16(16'h0644, 16'h9ABC);

    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R13", "reset outputs",
          {busy, done, mem_req}, 34'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fire(3, 3'd5);                     // R11 low priority ignored
    wait_idle("R11");
    check(rmem16(16'h0102) == 16'd2, "R11", "count untouched", 34'(rmem16(16'h0102)), 34'd2);

    fire(3, 3'd7);                     // R1 R3 R5 single 8-bit
    wait_idle("R3");
    check(rmem16(16'h0102) == 16'd1, "R3", "count decremented", 34'(rmem16(16'h0102)), 34'd1);
    check(mem[12'h301] == 8'h11 && mem[12'h300] == 8'h00, "R5", "odd byte lane",
          {mem[12'h301], mem[12'h300]}, 34'h1100);

    fire(3, 3'd7);                     // R8 chain rewrite
    wait_idle("R8");
    check(rmem16(16'h004C) == 16'h0180, "R8", "vector rewritten", 34'(rmem16(16'h004C)), 34'h0180);
    check(rmem16(16'h0104) == 16'h0602, "R4", "source advanced", 34'(rmem16(16'h0104)), 34'h0602);

    fire(3, 3'd7);                     // R9 no chain, R2 reserved bit
    wait_idle("R9");
    check(rmem16(16'h004C) == 16'h0180, "R9", "vector unchanged", 34'(rmem16(16'h004C)), 34'h0180);
    check(mem[12'h310] == 8'h5A, "R5", "odd source lane", 34'(mem[12'h310]), 34'h5A);

    fire(6, 3'd7);                     // R7 burst + R12 pending
    fire(5, 3'd7);
    wait_idle("R12");
    check(rmem16(16'h0344) == 16'h9ABC, "R7", "burst last word", 34'(rmem16(16'h0344)), 34'h9ABC);
    check(rmem16(16'h005A) == 16'hABCD, "R8", "chain high half", 34'(rmem16(16'h005A)), 34'hABCD);
    check(rmem16(16'h0320) == 16'hBEEF, "R6", "immediate data", 34'(rmem16(16'h0320)), 34'hBEEF);

    fire(5, 3'd7);                     // R6 second immediate, R2
    wait_idle("R6");
    check(rmem16(16'h0322) == 16'hBEEF, "R4", "dest advanced by 2", 34'(rmem16(16'h0322)), 34'hBEEF);

    fire(6, 3'd7);                     // R10 zero count
    wait_idle("R10");
    check(rmem16(16'h0262) == 16'd0, "R10", "zero descriptor untouched", 34'(rmem16(16'h0262)), 34'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule